// File: doc/BRIEF.md
# Vector Register Lane Fill and Extract Unit

This block keeps a file of 32 vector registers, 128 bits each, and performs lane-level moves between that file and a scalar datapath. A fill command copies the low element-sized bits of a scalar operand into every lane of one vector register. A copy command picks one lane of one register and returns it on the scalar result, either zero-extended or sign-extended to the scalar width. The element size is chosen per command: byte, halfword, word or doubleword.

A separate floating-point port reads and writes the same storage. Floating-point register n is the low 64 bits of vector register n. A full 64-bit write replaces that low doubleword. A 32-bit write touches only the low word or only the high word of it. The scalar width is a parameter, 64 or 32 bits. With a 32-bit scalar the doubleword element size is rejected for fill and copy.

Top module: `vreg_lane_unit`

## Requirements
- R1: While reset is asserted, and once it is released, every register reads as zero through both the copy path and the floating-point read port.
- R2: A fill (cmd_op = 1) with format 1 (byte), 2 (halfword), 3 (word) or 4 (doubleword) replicates the low 8/16/32/64 bits of scalar_in into all 16/8/4/2 lanes of the target register. The new value is visible after the next rising clock edge.
- R3: A zero-extending copy (cmd_op = 2) drives scalar_out combinationally with the selected lane, zero-extended to the scalar width.
- R4: A sign-extending copy (cmd_op = 3) drives scalar_out combinationally with the selected lane, sign-extended to the scalar width.
- R5: A copy selects lane cmd_idx modulo the lane count of its format. idx_err is high during a legal copy whose cmd_idx is not below the lane count (16, 8, 4 or 2). A copy never writes a register.
- R6: Format 0 or 5 to 7 on a fill or a copy, and format 4 when the scalar is 32 bits wide, raise illegal_op. In that case scalar_out is zero and no register changes. cmd_op = 0 does nothing.
- R7: fp_rdata combinationally shows bits 63:0 of the vector register selected by fp_reg.
- R8: An FP write with fp_wr_mode = 1 stores fp_wdata[31:0] into word lane 0 only. With fp_wr_mode = 2 it stores fp_wdata[31:0] into word lane 1 only. Word lanes 2 and 3 keep their values.
- R9: An FP write with fp_wr_mode = 0 replaces doubleword lane 0 with fp_wdata and keeps doubleword lane 1. fp_wr_mode = 3 writes nothing.
- R10: When a fill and an FP write hit the same register in the same cycle, the bits covered by the FP write take the FP data and all other bits take the fill value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 none, 1 fill, 2 zero-extending copy, 3 sign-extending copy |
| cmd_fmt | input | 3 | Element format: 1 byte, 2 half, 3 word, 4 doubleword |
| cmd_vreg | input | 5 | Target or source vector register |
| cmd_idx | input | 4 | Lane index for copies |
| scalar_in | input | XLEN | Scalar operand for fills |
| scalar_out | output | XLEN | Copy result, zero unless a legal copy is present |
| idx_err | output | 1 | Copy index beyond the lane count of its format |
| illegal_op | output | 1 | Command with an unsupported format |
| fp_wr_en | input | 1 | Floating-point write strobe |
| fp_wr_mode | input | 2 | 0 full 64-bit, 1 low word, 2 high word, 3 no write |
| fp_reg | input | 5 | Floating-point register for read and write |
| fp_wdata | input | 64 | Floating-point write data |
| fp_rdata | output | 64 | Low 64 bits of the selected vector register |

## Verification
A fill writes the same value into every lane, so fill and copy alone cannot show that a copy picks the right lane position. The bench first fills a register and then writes distinct bytes through the 64-bit and 32-bit floating-point port. This leaves the register with different lanes, and each lane position is then read back one by one. The second hard case is a fill and a floating-point write landing on the same register in the same cycle. The bench drives both at one clock edge and reads back all four words. A second instance with a 32-bit scalar covers the rejected doubleword format and the narrower sign extension.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_FILL  = 2'd1,
    OP_COPYU = 2'd2,
    OP_COPYS = 2'd3
  } lane_op_e;

  typedef enum logic [2:0] {
    FMT_VEC = 3'd0,
    FMT_B   = 3'd1,
    FMT_H   = 3'd2,
    FMT_W   = 3'd3,
    FMT_D   = 3'd4
  } lane_fmt_e;

  typedef enum logic [1:0] {
    FPW_FULL = 2'd0,
    FPW_LO   = 2'd1,
    FPW_HI   = 2'd2,
    FPW_NONE = 2'd3
  } fpw_mode_e;

  localparam int unsigned FP_W   = 64;
  localparam int unsigned FP_HW  = FP_W / 2;

endpackage

// File: rtl/vlane_cmd_decode.sv
module vlane_cmd_decode
  import vlane_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128,
  localparam int unsigned IDXW = $clog2(VLEN / 8),
  localparam int unsigned CW   = IDXW + 1
) (
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2:0]      cmd_fmt,
  input  logic [IDXW-1:0] cmd_idx,
  output logic            fill_go,
  output logic            copy_go,
  output logic            copy_sgn,
  output logic            illegal,
  output logic            idx_err
);

  localparam int unsigned NB = VLEN / 8;
  localparam int unsigned NH = VLEN / 16;
  localparam int unsigned NW = VLEN / 32;
  localparam int unsigned ND = VLEN / 64;

  logic          is_fill;
  logic          is_copy;
  logic          fmt_ok;
  logic [CW-1:0] lane_cnt;

  always_comb begin
    is_fill = cmd_valid && (lane_op_e'(cmd_op) == OP_FILL);
    is_copy = cmd_valid && ((lane_op_e'(cmd_op) == OP_COPYU) ||
                            (lane_op_e'(cmd_op) == OP_COPYS));
    fmt_ok   = 1'b0;
    lane_cnt = '0;
    case (lane_fmt_e'(cmd_fmt))
      FMT_B: begin fmt_ok = 1'b1;         lane_cnt = CW'(NB); end
      FMT_H: begin fmt_ok = 1'b1;         lane_cnt = CW'(NH); end
      FMT_W: begin fmt_ok = 1'b1;         lane_cnt = CW'(NW); end
      FMT_D: begin fmt_ok = (XLEN >= 64); lane_cnt = CW'(ND); end
      default: begin fmt_ok = 1'b0;       lane_cnt = '0;      end
    endcase
    illegal  = (is_fill || is_copy) && !fmt_ok;
    fill_go  = is_fill && fmt_ok;
    copy_go  = is_copy && fmt_ok;
    copy_sgn = lane_op_e'(cmd_op) == OP_COPYS;
    idx_err  = copy_go && ({1'b0, cmd_idx} >= lane_cnt);
  end

endmodule

// File: rtl/vlane_broadcast.sv
module vlane_broadcast
  import vlane_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128
) (
  input  logic [2:0]      fmt,
  input  logic [XLEN-1:0] scalar,
  output logic [VLEN-1:0] vec
);

  logic [63:0] s64;

  generate
    if (XLEN >= 64) begin : g_wide
      assign s64 = scalar[63:0];
    end else begin : g_narrow
      assign s64 = {{(64 - XLEN){1'b0}}, scalar};
    end
  endgenerate

  always_comb begin
    case (lane_fmt_e'(fmt))
      FMT_B:   vec = {(VLEN / 8){s64[7:0]}};
      FMT_H:   vec = {(VLEN / 16){s64[15:0]}};
      FMT_W:   vec = {(VLEN / 32){s64[31:0]}};
      FMT_D:   vec = {(VLEN / 64){s64}};
      default: vec = '0;
    endcase
  end

endmodule

// File: rtl/vlane_extract.sv
module vlane_extract
  import vlane_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128,
  localparam int unsigned IDXW = $clog2(VLEN / 8)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [2:0]      fmt,
  input  logic [IDXW-1:0] idx,
  input  logic            sgn,
  output logic [XLEN-1:0] result
);

  localparam int unsigned IH = IDXW - 1;
  localparam int unsigned IW = IDXW - 2;
  localparam int unsigned ID = IDXW - 3;

  logic [7:0]  eb;
  logic [15:0] eh;
  logic [31:0] ew;
  logic [63:0] ed;
  logic [63:0] ext;

  always_comb begin
    eb = vec[int'(idx) * 8 +: 8];
    eh = vec[int'(idx[IH-1:0]) * 16 +: 16];
    ew = vec[int'(idx[IW-1:0]) * 32 +: 32];
    ed = vec[int'(idx[ID-1:0]) * 64 +: 64];
    case (lane_fmt_e'(fmt))
      FMT_B:   ext = {{56{sgn & eb[7]}}, eb};
      FMT_H:   ext = {{48{sgn & eh[15]}}, eh};
      FMT_W:   ext = {{32{sgn & ew[31]}}, ew};
      FMT_D:   ext = ed;
      default: ext = '0;
    endcase
    result = ext[XLEN-1:0];
  end

endmodule

// File: rtl/vlane_regfile.sv
module vlane_regfile
  import vlane_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLEN = 128,
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [RW-1:0]   fill_reg,
  input  logic [VLEN-1:0] fill_vec,
  input  logic            fp_we,
  input  logic [1:0]      fp_mode,
  input  logic [RW-1:0]   fp_reg,
  input  logic [FP_W-1:0] fp_wdata,
  input  logic [RW-1:0]   rd_reg,
  output logic [VLEN-1:0] rd_vec,
  output logic [FP_W-1:0] fp_rdata
);

  logic [VLEN-1:0] rows [NREG];

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_row
      logic            fill_hit;
      logic            fp_hit;
      logic            row_en;
      logic [VLEN-1:0] row_d;
      logic [VLEN-1:0] row_q;

      always_comb begin
        fill_hit = fill_en && (fill_reg == RW'(r));
        fp_hit   = fp_we && (fp_reg == RW'(r)) &&
                   (fpw_mode_e'(fp_mode) != FPW_NONE);
        row_en   = fill_hit || fp_hit;
        row_d    = fill_hit ? fill_vec : row_q;
        if (fp_hit) begin
          case (fpw_mode_e'(fp_mode))
            FPW_FULL: row_d[FP_W-1:0]     = fp_wdata;
            FPW_LO:   row_d[FP_HW-1:0]    = fp_wdata[FP_HW-1:0];
            FPW_HI:   row_d[FP_W-1:FP_HW] = fp_wdata[FP_HW-1:0];
            default:  row_d = row_d;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q <= '0;
        end else if (row_en) begin
          row_q <= row_d;
        end
      end

      assign rows[r] = row_q;
    end
  endgenerate

  assign rd_vec   = rows[rd_reg];
  assign fp_rdata = rows[fp_reg][FP_W-1:0];

endmodule

// File: rtl/vreg_lane_unit.sv
module vreg_lane_unit
  import vlane_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned XLEN = 64,
  localparam int unsigned RW   = $clog2(NREG),
  localparam int unsigned IDXW = $clog2(VLEN / 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2:0]      cmd_fmt,
  input  logic [RW-1:0]   cmd_vreg,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic [XLEN-1:0] scalar_in,
  output logic [XLEN-1:0] scalar_out,
  output logic            idx_err,
  output logic            illegal_op,
  input  logic            fp_wr_en,
  input  logic [1:0]      fp_wr_mode,
  input  logic [RW-1:0]   fp_reg,
  input  logic [63:0]     fp_wdata,
  output logic [63:0]     fp_rdata
);

  logic [1:0]      rst_sync_q;
  logic            rst_sync_n;
  logic            fill_go;
  logic            copy_go;
  logic            copy_sgn;
  logic [VLEN-1:0] fill_vec;
  logic [VLEN-1:0] rd_vec;
  logic [XLEN-1:0] lane_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  vlane_cmd_decode #(.XLEN(XLEN), .VLEN(VLEN)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_fmt   (cmd_fmt),
    .cmd_idx   (cmd_idx),
    .fill_go   (fill_go),
    .copy_go   (copy_go),
    .copy_sgn  (copy_sgn),
    .illegal   (illegal_op),
    .idx_err   (idx_err)
  );

  vlane_broadcast #(.XLEN(XLEN), .VLEN(VLEN)) u_bcast (
    .fmt    (cmd_fmt),
    .scalar (scalar_in),
    .vec    (fill_vec)
  );

  vlane_regfile #(.NREG(NREG), .VLEN(VLEN)) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fill_en  (fill_go),
    .fill_reg (cmd_vreg),
    .fill_vec (fill_vec),
    .fp_we    (fp_wr_en),
    .fp_mode  (fp_wr_mode),
    .fp_reg   (fp_reg),
    .fp_wdata (fp_wdata),
    .rd_reg   (cmd_vreg),
    .rd_vec   (rd_vec),
    .fp_rdata (fp_rdata)
  );

  vlane_extract #(.XLEN(XLEN), .VLEN(VLEN)) u_extract (
    .vec    (rd_vec),
    .fmt    (cmd_fmt),
    .idx    (cmd_idx),
    .sgn    (copy_sgn),
    .result (lane_val)
  );

  assign scalar_out = copy_go ? lane_val : '0;

endmodule

// File: rtl/vreg_lane_unit_chk.sv
module vreg_lane_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [2:0]      cmd_fmt,
  input logic [RW-1:0]   cmd_vreg,
  input logic [XLEN-1:0] scalar_in,
  input logic [XLEN-1:0] scalar_out,
  input logic            idx_err,
  input logic            illegal_op,
  input logic            fp_wr_en,
  input logic [1:0]      fp_wr_mode,
  input logic [RW-1:0]   fp_reg,
  input logic [63:0]     fp_wdata,
  input logic [63:0]     fp_rdata
);

  // R6: a rejected command returns zero and is never flagged as an index error
  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (scalar_out == '0) && !idx_err);

  // R3: zero-extended byte copy has clear upper bits
  assert_copyu_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && cmd_fmt == 3'd1) |-> (scalar_out[XLEN-1:8] == '0));

  // R4: sign-extended byte copy has uniform upper bits
  assert_copys_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && cmd_fmt == 3'd1) |->
      ((~|scalar_out[XLEN-1:7]) || (&scalar_out[XLEN-1:7])));

  // R2: a word fill is seen by a word copy of the same register one cycle later
  assert_fill_then_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_fmt == 3'd3 && !fp_wr_en) |=>
      (!(cmd_valid && cmd_op == 2'd2 && cmd_fmt == 3'd3 && cmd_vreg == $past(cmd_vreg))
       || (scalar_out[31:0] == $past(scalar_in[31:0]))));

  // R9: a full 64-bit FP write reads back on the next cycle
  assert_fp_full_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_wr_en && fp_wr_mode == 2'd0) |=>
      ((fp_reg != $past(fp_reg)) || (fp_rdata == $past(fp_wdata))));

  // R8: a high-word FP write reads back in bits 63:32
  assert_fp_hi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_wr_en && fp_wr_mode == 2'd2) |=>
      ((fp_reg != $past(fp_reg)) || (fp_rdata[63:32] == $past(fp_wdata[31:0]))));

endmodule

bind vreg_lane_unit vreg_lane_unit_chk #(.XLEN(XLEN), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_fmt    (cmd_fmt),
  .cmd_vreg   (cmd_vreg),
  .scalar_in  (scalar_in),
  .scalar_out (scalar_out),
  .idx_err    (idx_err),
  .illegal_op (illegal_op),
  .fp_wr_en   (fp_wr_en),
  .fp_wr_mode (fp_wr_mode),
  .fp_reg     (fp_reg),
  .fp_wdata   (fp_wdata),
  .fp_rdata   (fp_rdata)
);

// File: tb/vreg_lane_unit_bench.sv
module vreg_lane_unit_bench;

  logic clk;
  logic rst_n;

  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_fmt;
  logic [4:0]  cmd_vreg;
  logic [3:0]  cmd_idx;
  logic [63:0] scalar_in;
  logic [63:0] scalar_out;
  logic        idx_err;
  logic        illegal_op;
  logic        fp_wr_en;
  logic [1:0]  fp_wr_mode;
  logic [4:0]  fp_reg;
  logic [63:0] fp_wdata;
  logic [63:0] fp_rdata;

  logic        b_valid;
  logic [1:0]  b_op;
  logic [2:0]  b_fmt;
  logic [4:0]  b_vreg;
  logic [3:0]  b_idx;
  logic [31:0] b_in;
  logic [31:0] b_out;
  logic        b_idx_err;
  logic        b_illegal;
  logic [63:0] b_fp_rdata;

  int n_chk;
  int n_fail;
  bit done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  vreg_lane_unit u_vreg_lane_unit (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_fmt(cmd_fmt),
    .cmd_vreg(cmd_vreg), .cmd_idx(cmd_idx), .scalar_in(scalar_in),
    .scalar_out(scalar_out), .idx_err(idx_err), .illegal_op(illegal_op),
    .fp_wr_en(fp_wr_en), .fp_wr_mode(fp_wr_mode), .fp_reg(fp_reg),
    .fp_wdata(fp_wdata), .fp_rdata(fp_rdata)
  );

  vreg_lane_unit #(.XLEN(32)) u_vreg_lane_unit_x32 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(b_valid), .cmd_op(b_op), .cmd_fmt(b_fmt),
    .cmd_vreg(b_vreg), .cmd_idx(b_idx), .scalar_in(b_in),
    .scalar_out(b_out), .idx_err(b_idx_err), .illegal_op(b_illegal),
    .fp_wr_en(1'b0), .fp_wr_mode(2'd0), .fp_reg(b_vreg),
    .fp_wdata(64'd0), .fp_rdata(b_fp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ext_val(input logic [63:0] s, input int fmt,
                                          input bit sgn, input int xl);
    int w;
    logic [63:0] m;
    logic [63:0] v;
    w = 8 << (fmt - 1);
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    v = s & m;
    if (sgn && v[w-1]) v = v | ~m;
    if (xl == 32) v = v & 64'hffff_ffff;
    return v;
  endfunction

  task automatic fill(input int r, input int f, input logic [63:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_fmt = 3'(f);
    cmd_vreg = 5'(r); scalar_in = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fpw(input int r, input int mode, input logic [63:0] d);
    @(negedge clk);
    fp_wr_en = 1'b1; fp_wr_mode = 2'(mode); fp_reg = 5'(r); fp_wdata = d;
    @(negedge clk);
    fp_wr_en = 1'b0;
  endtask

  task automatic copy_chk(input int r, input int f, input int idx, input bit sgn,
                          input logic [63:0] exp, input bit exp_err,
                          input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = sgn ? 2'd3 : 2'd2; cmd_fmt = 3'(f);
    cmd_vreg = 5'(r); cmd_idx = 4'(idx);
    #1;
    chk(scalar_out === exp, req, scalar_out, exp);
    chk(idx_err === exp_err, "R5", 64'(idx_err), 64'(exp_err));
    cmd_valid = 1'b0;
  endtask

  task automatic fpr_chk(input int r, input logic [63:0] exp, input string req);
    @(negedge clk);
    fp_reg = 5'(r);
    #1;
    chk(fp_rdata === exp, req, fp_rdata, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [2];
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_fmt = 3'd0; cmd_vreg = 5'd0;
    cmd_idx = 4'd0; scalar_in = 64'd0;
    fp_wr_en = 1'b0; fp_wr_mode = 2'd0; fp_reg = 5'd0; fp_wdata = 64'd0;
    b_valid = 1'b0; b_op = 2'd0; b_fmt = 3'd0; b_vreg = 5'd0; b_idx = 4'd0;
    b_in = 32'd0;
    pats[0] = 64'h9e76_89ac_a512_b683;
    pats[1] = 64'h1234_5678_7654_3210;

    repeat (3) @(negedge clk);
    fp_reg = 5'd7;
    #1 chk(fp_rdata === 64'd0, "R1 in reset", fp_rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every register reads zero after reset
    for (int r = 0; r < 32; r++) fpr_chk(r, 64'd0, "R1");
    copy_chk(31, 3, 3, 1'b0, 64'd0, 1'b0, "R1 upper word");

    // R2 R3 R4 R5: sweep formats, lanes and extension kind
    for (int p = 0; p < 2; p++) begin
      for (int f = 1; f <= 4; f++) begin
        int r;
        r = 10 + f * 2 + p;
        fill(r, f, pats[p]);
        for (int idx = 0; idx < 16; idx++) begin
          for (int s = 0; s < 2; s++) begin
            bit e;
            e = idx >= (16 >> (f - 1));
            copy_chk(r, f, idx, s[0], ext_val(pats[p], f, s[0], 64), e,
                     s[0] ? "R4 sweep" : "R3 sweep");
          end
        end
      end
    end

    // R2: fill replicated value read back through the FP port
    fill(3, 1, 64'ha512_b683);
    fpr_chk(3, 64'h8383_8383_8383_8383, "R2 byte fill fp view");
    fill(3, 2, 64'ha512_b683);
    fpr_chk(3, 64'hb683_b683_b683_b683, "R2 half fill fp view");

    // R3 R4 positional: give lanes distinct values through the FP port
    fill(30, 3, 64'hcafe_f00d);
    fpw(30, 0, 64'h8877_6655_4433_2211);
    for (int i = 0; i < 8; i++)
      copy_chk(30, 1, i, 1'b0, 64'(8'h11 * (i + 1)), 1'b0, "R3 byte position");
    copy_chk(30, 1, 8,  1'b0, 64'h0d, 1'b0, "R3 byte position hi");
    copy_chk(30, 1, 11, 1'b0, 64'hca, 1'b0, "R3 byte position hi");
    copy_chk(30, 2, 3, 1'b1, 64'hffff_ffff_ffff_8877, 1'b0, "R4 half position");
    copy_chk(30, 2, 1, 1'b1, 64'h0000_0000_0000_4433, 1'b0, "R4 half positive");
    copy_chk(30, 4, 1, 1'b1, 64'hcafe_f00d_cafe_f00d, 1'b0, "R9 upper dword kept");
    copy_chk(30, 4, 3, 1'b0, 64'hcafe_f00d_cafe_f00d, 1'b1, "R5 dword modulo");
    copy_chk(30, 3, 6, 1'b0, 64'hcafe_f00d, 1'b1, "R5 word modulo");

    // R8: 32-bit FP writes touch only one word lane
    fill(0, 3, 64'haaaa_aaaa);
    fill(2, 3, 64'haaaa_aaaa);
    fpw(0, 1, 64'h5555_5555);
    fpw(2, 2, 64'h5555_5555);
    copy_chk(0, 3, 0, 1'b0, 64'h5555_5555, 1'b0, "R8 low word");
    copy_chk(0, 3, 1, 1'b0, 64'haaaa_aaaa, 1'b0, "R8 low word");
    copy_chk(0, 3, 2, 1'b0, 64'haaaa_aaaa, 1'b0, "R8 low word");
    copy_chk(2, 3, 0, 1'b0, 64'haaaa_aaaa, 1'b0, "R8 high word");
    copy_chk(2, 3, 1, 1'b0, 64'h5555_5555, 1'b0, "R8 high word");
    copy_chk(2, 3, 3, 1'b0, 64'haaaa_aaaa, 1'b0, "R8 high word");
    // R7: FP read view concatenates word lanes 1 and 0
    fpr_chk(0, 64'haaaa_aaaa_5555_5555, "R7");
    fpr_chk(2, 64'h5555_5555_aaaa_aaaa, "R7");

    // R9: full FP write, then mode 3 has no effect
    fill(4, 4, 64'haaaa_aaaa_aaaa_aaaa);
    fpw(4, 0, 64'h5555_5555_5555_5555);
    copy_chk(4, 4, 0, 1'b0, 64'h5555_5555_5555_5555, 1'b0, "R9 dword lane 0");
    copy_chk(4, 4, 1, 1'b0, 64'haaaa_aaaa_aaaa_aaaa, 1'b0, "R9 dword lane 1");
    fpw(4, 3, 64'h0123_0123_0123_0123);
    fpr_chk(4, 64'h5555_5555_5555_5555, "R9 mode 3 no write");
    // R2 R7: fill after FP write overrides the FP view
    fpw(6, 0, 64'haaaa_aaaa_aaaa_aaaa);
    fill(6, 3, 64'h5555_5555);
    fpr_chk(6, 64'h5555_5555_5555_5555, "R7 fill over fp");

    // R10: fill and FP high-word write collide on one register
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_fmt = 3'd3; cmd_vreg = 5'd9;
    scalar_in = 64'h0f0f_0f0f;
    fp_wr_en = 1'b1; fp_wr_mode = 2'd2; fp_reg = 5'd9; fp_wdata = 64'hdead_beef;
    @(negedge clk);
    cmd_valid = 1'b0; fp_wr_en = 1'b0;
    copy_chk(9, 3, 0, 1'b0, 64'h0f0f_0f0f, 1'b0, "R10 word 0");
    copy_chk(9, 3, 1, 1'b0, 64'hdead_beef, 1'b0, "R10 word 1");
    copy_chk(9, 3, 2, 1'b0, 64'h0f0f_0f0f, 1'b0, "R10 word 2");
    copy_chk(9, 3, 3, 1'b0, 64'h0f0f_0f0f, 1'b0, "R10 word 3");

    // R6: illegal formats flag, return zero and write nothing
    fill(5, 3, 64'h1122_3344);
    for (int f = 0; f < 8; f++) begin
      if (f == 0 || f >= 5) begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_fmt = 3'(f); cmd_vreg = 5'd5;
        scalar_in = '1;
        #1 chk(illegal_op === 1'b1, "R6 fill flag", 64'(illegal_op), 64'd1);
        @(negedge clk);
        cmd_op = 2'd3; cmd_idx = 4'd0;
        #1 chk(illegal_op === 1'b1, "R6 copy flag", 64'(illegal_op), 64'd1);
        chk(scalar_out === 64'd0, "R6 copy zero", scalar_out, 64'd0);
        cmd_valid = 1'b0;
        copy_chk(5, 3, 2, 1'b0, 64'h1122_3344, 1'b0, "R6 unchanged");
      end
    end
    // R6: op none with valid writes nothing
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_fmt = 3'd3; cmd_vreg = 5'd5;
    scalar_in = 64'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    copy_chk(5, 3, 1, 1'b0, 64'h1122_3344, 1'b0, "R6 op none");

    // 32-bit scalar instance
    @(negedge clk);
    b_valid = 1'b1; b_op = 2'd1; b_fmt = 3'd1; b_vreg = 5'd1; b_in = 32'ha512_b683;
    @(negedge clk);
    b_op = 2'd3; b_idx = 4'd8;
    #1 chk(64'(b_out) === 64'hffff_ff83, "R4 x32 byte", 64'(b_out), 64'hffff_ff83);
    @(negedge clk);
    b_op = 2'd1; b_fmt = 3'd2; b_vreg = 5'd2;
    @(negedge clk);
    b_op = 2'd2; b_idx = 4'd6;
    #1 chk(64'(b_out) === 64'h0000_b683, "R3 x32 half", 64'(b_out), 64'h0000_b683);
    b_op = 2'd3; b_idx = 4'd5;
    #1 chk(64'(b_out) === 64'hffff_b683, "R4 x32 half", 64'(b_out), 64'hffff_b683);
    @(negedge clk);
    b_op = 2'd1; b_fmt = 3'd4; b_vreg = 5'd3; b_in = 32'hffff_ffff;
    #1 chk(b_illegal === 1'b1, "R6 x32 dword fill", 64'(b_illegal), 64'd1);
    @(negedge clk);
    b_op = 2'd2; b_fmt = 3'd4; b_idx = 4'd0;
    #1 chk(b_illegal === 1'b1, "R6 x32 dword copy", 64'(b_illegal), 64'd1);
    chk(64'(b_out) === 64'd0, "R6 x32 copy zero", 64'(b_out), 64'd0);
    b_fmt = 3'd3;
    #1 chk(64'(b_out) === 64'd0, "R6 x32 no write", 64'(b_out), 64'd0);
    chk(b_fp_rdata === 64'd0, "R6 x32 no write fp", b_fp_rdata, 64'd0);
    @(negedge clk);
    b_valid = 1'b0;

    // R1: reset in mid-run clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    fp_reg = 5'd12;
    #1 chk(fp_rdata === 64'd0, "R1 mid reset", fp_rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    copy_chk(30, 3, 3, 1'b0, 64'd0, 1'b0, "R1 after reset");
    fpr_chk(9, 64'd0, "R1 after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule